// File: doc/BRIEF.md
# Queued Pipelined-Bus Register Slave

This block is a register-file slave for a pipelined bus handshake. A master raises a cycle-valid line for the whole transaction and a strobe for each request. It may present a new request on every clock for as long as the slave's stall output is low. Accepted requests wait in a small first-in first-out queue. A single processing stage takes them one at a time and holds each for a fixed number of cycles. When a request retires, the slave answers through a registered acknowledge pulse, with the read data alongside it.

Because the acknowledge comes from a flip-flop, no combinational path runs from the master's request back to the master's acknowledge input. The price is one cycle of latency. The stall output is taken from the queue occupancy register, so it too starts at a flop.

A parameter selects a direct variant with no queue. In that variant every request is served on the edge that accepts it, stall is tied low, and only the registered acknowledge delay remains. Dropping the cycle-valid line abandons all outstanding work.

Top module: `pipe_slave`

## Requirements
- R1: A request is accepted on a rising edge where cyc_i=1, stb_i=1 and stall_o=0. A request presented while stall_o=1 is not taken, so a master that holds stb_i through a stall receives exactly one ack_o per request.
- R2: stall_o=1 exactly when QUEUE_DEPTH requests sit in the queue. A request leaves the queue when the processing stage, which holds one request, takes it. With the defaults, back-to-back requests into an idle slave see stall_o rise after the sixth acceptance.
- R3: A request accepted on edge k, with the queue empty and the processing stage idle, gives ack_o=1 in the cycle after edge k+LATENCY and ack_o=0 in the cycles between.
- R4: Requests are served in arrival order. Each accepted request yields exactly one acknowledge pulse lasting one cycle, and acknowledges of queued requests are LATENCY cycles apart.
- R5: For a read (we_i=0), dat_o carries the addressed register in the cycle where ack_o=1. dat_o is 0 in every other cycle and for write acknowledges.
- R6: A write (we_i=1) stores dat_i in register adr_i when it retires, and later reads return the stored value.
- R7: An address at or above NUM_REGS reads as 0. A write to such an address changes no register, and the request is still acknowledged.
- R8: A rising edge with cyc_i=0 empties the queue and the processing stage. Abandoned requests get no ack_o and perform no write, and stall_o is 0 afterwards.
- R9: When the queue is full, no request is accepted and one entry moves to the processing stage, stall_o is 0 in the next cycle. With the defaults, stall_o stays high for two cycles after the queue fills when the master then stops issuing.
- R10: With SINGLE_CYCLE=1, stall_o is always 0, and a request accepted on edge k is acknowledged with its data in the cycle after edge k, so requests can be acknowledged on consecutive cycles.
- R11: After reset, ack_o=0, stall_o=0, dat_o=0 and all registers hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Transaction valid; low abandons outstanding work |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Register address |
| dat_i | input | DATA_W | Write data |
| ack_o | output | 1 | Registered acknowledge pulse |
| stall_o | output | 1 | Queue full, request not accepted |
| dat_o | output | DATA_W | Read data, valid with ack_o |

## Verification
The bench builds two instances. One uses the defaults: a four-entry queue, a three-cycle service time and twelve registers behind a four-bit address. The other sets SINGLE_CYCLE=1 and leaves the rest as they are. In the queued instance, the short queue and the small gap between service time and depth let back-to-back bursts fill the queue and draw stall_o within a handful of cycles. The four unused addresses give out-of-range reads and writes. The direct instance covers acknowledges on consecutive cycles with no stall at all.

// File: rtl/pipe_slave_pkg.sv
package pipe_slave_pkg;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    // Circular pointer step for a buffer of arbitrary depth.
    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr + 1 >= depth) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/pipe_slave_queue.sv
module pipe_slave_queue
    import pipe_slave_pkg::*;
#(
    parameter int unsigned WIDTH = 37,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic             full,
    output logic             valid,
    output logic [WIDTH-1:0] rdata
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t                      st_d, st_q;
    logic [DEPTH-1:0][WIDTH-1:0]  mem_d, mem_q;

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) begin
                mem_d[st_q.wr] = wdata;
                st_d.wr        = PTR_W'(wrap_inc(32'(st_q.wr), DEPTH));
            end
            if (pop) begin
                st_d.rd = PTR_W'(wrap_inc(32'(st_q.rd), DEPTH));
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
                2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            mem_q <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign valid = (st_q.cnt != '0);
    assign rdata = mem_q[st_q.rd];

endmodule

// File: rtl/pipe_slave_engine.sv
module pipe_slave_engine
    import pipe_slave_pkg::*;
#(
    parameter int unsigned WIDTH   = 37,
    parameter int unsigned LATENCY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             q_valid,
    input  logic [WIDTH-1:0] q_data,
    output logic             pop,
    output logic             retire,
    output logic [WIDTH-1:0] job
);

    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        eng_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] job;
    } estate_t;

    estate_t est_d, est_q;

    always_comb begin
        pop    = (est_q.st == ENG_IDLE) && q_valid && !flush;
        retire = (est_q.st == ENG_BUSY) && (est_q.cnt == CNT_W'(1)) && !flush;

        est_d = est_q;
        if (flush) begin
            est_d.st = ENG_IDLE;
        end else if (pop) begin
            est_d.st  = ENG_BUSY;
            est_d.cnt = CNT_W'(LATENCY - 1);
            est_d.job = q_data;
        end else if (est_q.st == ENG_BUSY) begin
            est_d.cnt = est_q.cnt - CNT_W'(1);
            if (retire) begin
                est_d.st = ENG_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est_q <= '{st: ENG_IDLE, cnt: '0, job: '0};
        end else begin
            est_q <= est_d;
        end
    end

    assign job = est_q.job;

endmodule

// File: rtl/pipe_slave_regs.sv
module pipe_slave_regs #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] wdat,
    output logic [DATA_W-1:0] rdat
);

    logic [NUM_REGS-1:0][DATA_W-1:0] mem_d, mem_q;

    // Addresses without a matching register fall through: read 0, no write.
    always_comb begin
        mem_d = mem_q;
        rdat  = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (adr == ADDR_W'(i)) begin
                rdat = mem_q[i];
                if (wr_en) begin
                    mem_d[i] = wdat;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/pipe_slave.sv
module pipe_slave
    import pipe_slave_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_REGS     = 12,
    parameter int unsigned QUEUE_DEPTH  = 4,
    parameter int unsigned LATENCY      = 3,
    parameter bit          SINGLE_CYCLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              ack_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] dat_o
);

    localparam int unsigned REQ_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] dat;
    } resp_t;

    logic              srv_fire;
    logic [REQ_W-1:0]  srv_req;
    logic              srv_we;
    logic [ADDR_W-1:0] srv_adr;
    logic [DATA_W-1:0] srv_dat;
    logic [DATA_W-1:0] reg_rdat;
    logic              stall_w;
    resp_t             resp_d, resp_q;

    if (NUM_REGS > (1 << ADDR_W)) begin : g_chk_regs
        $error("pipe_slave: NUM_REGS exceeds the address space");
    end

    if (SINGLE_CYCLE) begin : g_direct
        assign stall_w  = 1'b0;
        assign srv_fire = cyc_i && stb_i;
        assign srv_req  = {we_i, adr_i, dat_i};
    end else begin : g_queued
        logic             accept;
        logic             q_full;
        logic             q_valid;
        logic             q_pop;
        logic [REQ_W-1:0] q_head;

        if (LATENCY < 2) begin : g_chk_lat
            $error("pipe_slave: queued variant needs LATENCY >= 2");
        end

        assign accept  = cyc_i && stb_i && !q_full;
        assign stall_w = q_full;

        pipe_slave_queue #(
            .WIDTH (REQ_W),
            .DEPTH (QUEUE_DEPTH)
        ) i_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (!cyc_i),
            .push  (accept),
            .wdata ({we_i, adr_i, dat_i}),
            .pop   (q_pop),
            .full  (q_full),
            .valid (q_valid),
            .rdata (q_head)
        );

        pipe_slave_engine #(
            .WIDTH   (REQ_W),
            .LATENCY (LATENCY)
        ) i_engine (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (!cyc_i),
            .q_valid (q_valid),
            .q_data  (q_head),
            .pop     (q_pop),
            .retire  (srv_fire),
            .job     (srv_req)
        );
    end

    assign srv_we  = srv_req[REQ_W-1];
    assign srv_adr = srv_req[DATA_W +: ADDR_W];
    assign srv_dat = srv_req[DATA_W-1:0];

    pipe_slave_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (srv_fire && srv_we),
        .adr   (srv_adr),
        .wdat  (srv_dat),
        .rdat  (reg_rdat)
    );

    always_comb begin
        resp_d.ack = srv_fire;
        resp_d.dat = (srv_fire && !srv_we) ? reg_rdat : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign ack_o   = resp_q.ack;
    assign dat_o   = resp_q.dat;
    assign stall_o = stall_w;

endmodule

// File: rtl/pipe_slave_chk.sv
module pipe_slave_chk #(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned QUEUE_DEPTH  = 4,
    parameter bit          SINGLE_CYCLE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              ack_o,
    input logic              stall_o,
    input logic [DATA_W-1:0] dat_o
);

    // Requests accepted and not yet acknowledged in the current transaction.
    logic [15:0] outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else if (!cyc_i) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_q + 16'(stb_i && !stall_o) - 16'(ack_o);
        end
    end

    AST_ACK_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (outst_q != '0));                                       // R4

    AST_ACK_NEEDS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cyc_i));                                          // R8

    AST_FLUSH_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |=> !stall_o);                                             // R8

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (dat_o == '0));                                        // R5

    AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (outst_q >= 16'(QUEUE_DEPTH)));                       // R2

    if (SINGLE_CYCLE) begin : g_direct
        AST_DIRECT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            !stall_o);                                                    // R10

        AST_DIRECT_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_i && stb_i) |=> ack_o);                                  // R10
    end else begin : g_queued
        AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ack_o |=> !ack_o);                                            // R4
    end

endmodule

bind pipe_slave pipe_slave_chk #(
    .DATA_W       (DATA_W),
    .QUEUE_DEPTH  (QUEUE_DEPTH),
    .SINGLE_CYCLE (SINGLE_CYCLE)
) i_pipe_slave_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_i   (cyc_i),
    .stb_i   (stb_i),
    .ack_o   (ack_o),
    .stall_o (stall_o),
    .dat_o   (dat_o)
);

// File: tb/test_pipe_slave.sv
module test_pipe_slave;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    typedef struct packed {
        logic        we;
        logic [3:0]  adr;
        logic [31:0] wdat;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 4'd0,  32'h1111_0000, 32'h0},
        '{1'b1, 4'd5,  32'h5555_0005, 32'h0},
        '{1'b1, 4'd11, 32'hBBBB_000B, 32'h0},
        '{1'b1, 4'd12, 32'hCCCC_000C, 32'h0},
        '{1'b0, 4'd0,  32'h0,         32'h1111_0000},
        '{1'b0, 4'd5,  32'h0,         32'h5555_0005},
        '{1'b0, 4'd11, 32'h0,         32'hBBBB_000B},
        '{1'b0, 4'd12, 32'h0,         32'h0},
        '{1'b0, 4'd4,  32'h0,         32'h0},
        '{1'b0, 4'd15, 32'h0,         32'h0},
        '{1'b1, 4'd5,  32'h5A5A_5A5A, 32'h0},
        '{1'b0, 4'd5,  32'h0,         32'h5A5A_5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0]  adr = '0;
    logic [31:0] dat = '0;
    logic        ack, stall;
    logic [31:0] rdat;

    logic        b_cyc = 1'b0, b_stb = 1'b0, b_we = 1'b0;
    logic [3:0]  b_adr = '0;
    logic [31:0] b_dat = '0;
    logic        b_ack, b_stall;
    logic [31:0] b_rdat;

    int checks = 0;
    int errors = 0;
    int ack_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (ack) ack_cnt++;

    pipe_slave i_pipe_slave (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(dat), .ack_o(ack), .stall_o(stall), .dat_o(rdat)
    );

    pipe_slave #(.SINGLE_CYCLE(1'b1)) i_pipe_slave_1c (
        .clk(clk), .rst_n(rst_n), .cyc_i(b_cyc), .stb_i(b_stb), .we_i(b_we),
        .adr_i(b_adr), .dat_i(b_dat), .ack_o(b_ack), .stall_o(b_stall), .dat_o(b_rdat)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request into an idle slave; checks the latency window and the data.
    task automatic txn(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] e, input string req);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d;
        check("R1", "stall before request", 32'(stall), 32'h0);
        @(negedge clk);
        stb = 1'b0;
        for (int j = 1; j <= LAT + 1; j++) begin
            @(negedge clk);
            if (j < LAT) begin
                check("R3", "ack early", 32'(ack), 32'h0);
            end else if (j == LAT) begin
                check("R3", "ack at latency", 32'(ack), 32'h1);
                check(req, "data with ack", rdat, e);
            end else begin
                check("R4", "ack single pulse", 32'(ack), 32'h0);
                check("R5", "data after ack", rdat, 32'h0);
            end
        end
    endtask

    // Back-to-back requests to registers 0..n-1, holding a request through stalls.
    task automatic burst(input logic w, input int n, output int first_run, output int nacks);
        int run_l = 0;
        int got_l = 0;
        fork
            begin
                int  sent = 0;
                bit  seen = 1'b0;
                bit  acc;
                @(negedge clk);
                while (sent < n) begin
                    cyc = 1'b1; stb = 1'b1; we = w;
                    adr = 4'(sent); dat = 32'hA0 + 32'(sent);
                    acc = !stall;
                    if (stall) seen = 1'b1;
                    else if (!seen) run_l++;
                    @(negedge clk);
                    if (acc) sent++;
                end
                stb = 1'b0;
            end
            begin
                for (int c = 0; c < n * LAT + 3 * LAT + 10; c++) begin
                    @(negedge clk);
                    if (ack) begin
                        check("R4", "burst order data", rdat,
                              w ? 32'h0 : 32'hA0 + 32'(got_l));
                        got_l++;
                    end
                end
            end
        join
        first_run = run_l;
        nacks     = got_l;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int run;
        int n;
        int base;
        int high;
        int acc;

        // Reset state, R11
        repeat (3) @(negedge clk);
        check("R11", "ack in reset", 32'(ack), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "ack after reset", 32'(ack), 32'h0);
        check("R11", "stall after reset", 32'(stall), 32'h0);
        check("R11", "data after reset", rdat, 32'h0);
        check("R11", "direct stall after reset", 32'(b_stall), 32'h0);
        check("R11", "direct ack after reset", 32'(b_ack), 32'h0);

        // Table of single transactions: R3 R5 R6 R7
        foreach (VECS[i]) begin
            txn(VECS[i].we, VECS[i].adr, VECS[i].wdat, VECS[i].exp,
                (VECS[i].adr >= 4'd12) ? "R7" : (VECS[i].we ? "R6" : "R5"));
        end
        txn(1'b0, 4'd7, 32'h0, 32'h0, "R11");

        // Bursts: R1 R2 R4 (defaults: stall after 6 acceptances)
        burst(1'b1, 8, run, n);
        check("R1", "write burst ack count", 32'(n), 32'd8);
        check("R2", "accepts before stall", 32'(run), 32'd6);
        burst(1'b0, 8, run, n);
        check("R1", "read burst ack count", 32'(n), 32'd8);
        repeat (4) @(negedge clk);

        // Fill then stop issuing: R9, stall high for 2 cycles with defaults
        base = ack_cnt;
        acc  = 0;
        high = 0;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 4'd3;
        while (!stall && acc < 20) begin
            @(negedge clk);
            acc++;
        end
        stb = 1'b0;
        check("R2", "acceptances to fill", 32'(acc), 32'd6);
        while (stall && high < 20) begin
            high++;
            @(negedge clk);
        end
        check("R9", "stall cycles after fill", 32'(high), 32'd2);
        repeat (6 * LAT + 4) @(negedge clk);
        check("R4", "acks after fill", 32'(ack_cnt - base), 32'd6);

        // Flush with work in flight: R8
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b1;
        for (int k = 0; k < 3; k++) begin
            adr = 4'(2 + k); dat = 32'hF0 + 32'(k);
            @(negedge clk);
        end
        base = ack_cnt;
        cyc = 1'b0; stb = 1'b0;
        repeat (3 * LAT + 4) @(negedge clk);
        check("R8", "acks after flush", 32'(ack_cnt - base), 32'h0);
        check("R8", "stall after flush", 32'(stall), 32'h0);
        txn(1'b0, 4'd2, 32'h0, 32'hA2, "R8");
        txn(1'b0, 4'd3, 32'h0, 32'hA3, "R8");
        txn(1'b0, 4'd4, 32'h0, 32'hA4, "R8");

        // Direct variant: R10
        @(negedge clk);
        b_cyc = 1'b1; b_stb = 1'b1; b_we = 1'b1; b_adr = 4'd1; b_dat = 32'h1234;
        check("R10", "direct stall", 32'(b_stall), 32'h0);
        @(negedge clk);
        check("R10", "direct ack write", 32'(b_ack), 32'h1);
        check("R10", "direct write data", b_rdat, 32'h0);
        b_adr = 4'd13; b_dat = 32'h9999;
        @(negedge clk);
        check("R10", "direct ack write 2", 32'(b_ack), 32'h1);
        check("R10", "direct stall held low", 32'(b_stall), 32'h0);
        b_we = 1'b0; b_adr = 4'd1;
        @(negedge clk);
        check("R10", "direct ack read", 32'(b_ack), 32'h1);
        check("R10", "direct read data", b_rdat, 32'h1234);
        b_adr = 4'd13;
        @(negedge clk);
        check("R10", "direct ack read 2", 32'(b_ack), 32'h1);
        check("R7", "direct out-of-range read", b_rdat, 32'h0);
        b_stb = 1'b0;
        @(negedge clk);
        check("R10", "direct no request no ack", 32'(b_ack), 32'h0);
        b_cyc = 1'b0; b_stb = 1'b1;
        @(negedge clk);
        check("R8", "direct strobe without cycle", 32'(b_ack), 32'h0);
        b_stb = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule